// File: doc/BRIEF.md
# Host State Consistency Checker

This block decides whether the host-side state and the entry/exit controls prepared for a virtual-machine entry are consistent enough to allow the entry. A sequencer presents all fields at once and raises `start` for one cycle. On the next cycle the block raises `done` for one cycle. It also presents a single `pass` flag and a vector in which each bit names one violated rule.

The rules cover several areas: the low bits and null values of the host segment selectors, and how the address-space-size control agrees with long-mode state and with the 64-bit-guest control. They also cover the reserved high bits of the host page-table base, the physical reach of the last byte of an MSR load area, the SMM-related controls, and the canonical form of the linear addresses. The physical-address width is a run-time input, and a width outside the supported range is itself reported.

Top module: `host_state_checker`

## Requirements
- R1: err[0] is set when any of the seven selectors (code, stack, four data, task) has a nonzero value in bits 2:0.
- R2: err[1] is set when the code or task selector is zero, or when the stack selector is zero while `host64` is 0.
- R3: err[2] is set when `lma` is 0 and either `host64` or `guest64` is 1, or when `lma` is 1 and `host64` is 0.
- R4: err[3] is set when `host64` is 0 and either `guest64` is 1 or `host_rip[63:32]` is nonzero.
- R5: err[4] is set when `host64` is 1 and either `cr4_pae` is 0 or `host_rip` is not canonical.
- R6: err[5] is set when `host_cr3` has any bit set at or above the effective width. The effective width is `pa_width`, limited to 52.
- R7: When `msr_count` is nonzero, err[6] is set if `msr_addr + 16*msr_count - 1` has any bit set at or above the effective width. The sum is formed without truncation to 64 bits. A zero count never sets err[6].
- R8: err[7] is set when `smm_entry` or `dual_off` is 1 while `in_smm` is 0, or when both are 1.
- R9: err[8] is set when any of the seven checked addresses is not canonical. These are the sysenter stack pointer, the sysenter instruction pointer, and the FS, GS, GDTR, IDTR and TR bases. An address is canonical when bits 63:47 are all equal.
- R10: err[9] is set when `pa_width` is below 32 or above 52.
- R11: Inputs are sampled on a clock edge that sees `start` high. On the next cycle `done` is high for exactly one cycle, `err` shows the rule results, and `pass` is 1 exactly when `err` is all zero. The outputs hold until the next start. Reset clears `done`, `pass` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample all fields this cycle |
| pa_width | input | 6 | Physical-address width in bits |
| lma | input | 1 | Long mode currently active |
| host64 | input | 1 | Host address-space-size exit control |
| guest64 | input | 1 | 64-bit guest entry control |
| smm_entry | input | 1 | Enter-SMM entry control |
| dual_off | input | 1 | Deactivate-dual-monitor entry control |
| in_smm | input | 1 | Processor currently in SMM |
| cr4_pae | input | 1 | Host CR4 physical-address-extension bit |
| host_cr3 | input | 64 | Host page-table base |
| host_rip | input | 64 | Host instruction pointer |
| sysenter_esp | input | 64 | Host sysenter stack pointer |
| sysenter_eip | input | 64 | Host sysenter instruction pointer |
| fs_base | input | 64 | Host FS base |
| gs_base | input | 64 | Host GS base |
| gdtr_base | input | 64 | Host GDTR base |
| idtr_base | input | 64 | Host IDTR base |
| tr_base | input | 64 | Host TR base |
| sel_cs | input | 16 | Code selector |
| sel_ss | input | 16 | Stack selector |
| sel_ds | input | 16 | Data selector |
| sel_es | input | 16 | Extra selector |
| sel_fs | input | 16 | FS selector |
| sel_gs | input | 16 | GS selector |
| sel_tr | input | 16 | Task selector |
| msr_addr | input | 64 | MSR load area start address |
| msr_count | input | 32 | MSR load area entry count |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | All rules satisfied |
| err | output | 10 | Per-rule violation bits |

## Verification
The bench builds the block with its defaults: 64-bit addresses, a 32-bit entry count, a width limit of 52 and a canonical boundary at bit 47. These values bring a carry out of bit 63 in the load-area sum within reach. So are a page-table base one bit under and at the width boundary, and a sign break exactly at bit 47. Widths of 31, 52 and 53 exercise both range limits and the clamp.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    localparam int ERR_W   = 10;
    localparam int PAW_W   = 6;
    localparam int N_SEL   = 7;
    localparam int N_CANON = 7;

    localparam int E_SEL_BITS = 0;
    localparam int E_SEL_NULL = 1;
    localparam int E_LMA      = 2;
    localparam int E_HOST32   = 3;
    localparam int E_HOST64   = 4;
    localparam int E_CR3      = 5;
    localparam int E_MSR      = 6;
    localparam int E_SMM      = 7;
    localparam int E_CANON    = 8;
    localparam int E_PAW      = 9;

    typedef enum logic [2:0] {
        SI_CS = 3'd0, SI_SS = 3'd1, SI_DS = 3'd2, SI_ES = 3'd3,
        SI_FS = 3'd4, SI_GS = 3'd5, SI_TR = 3'd6
    } sel_idx_e;

    typedef struct packed {
        logic             pass;
        logic [ERR_W-1:0] err;
    } hsc_result_t;

    function automatic logic is_canon(input logic [63:0] v, input int msb);
        logic [63:0] hi;
        hi = v >> msb;
        return (hi == '0) || (hi == ({64{1'b1}} >> msb));
    endfunction

endpackage

// File: rtl/hsc_sel_rules.sv
module hsc_sel_rules
    import hsc_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic [N_SEL-1:0][SEL_W-1:0] sels,
    input  logic                        host64,
    output logic                        low_bad,
    output logic                        null_bad
);
    logic [N_SEL-1:0] low_hit;

    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        assign low_hit[g] = |sels[g][2:0];
    end

    always_comb begin
        low_bad  = |low_hit;
        null_bad = (sels[SI_CS] == '0) || (sels[SI_TR] == '0) ||
                   (!host64 && (sels[SI_SS] == '0));
    end
endmodule

// File: rtl/hsc_mode_rules.sv
module hsc_mode_rules
    import hsc_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CANON_MSB = 47
) (
    input  logic              lma,
    input  logic              host64,
    input  logic              guest64,
    input  logic              cr4_pae,
    input  logic [ADDR_W-1:0] rip,
    input  logic              smm_entry,
    input  logic              dual_off,
    input  logic              in_smm,
    output logic              lma_bad,
    output logic              h32_bad,
    output logic              h64_bad,
    output logic              smm_bad
);
    localparam int HALF = ADDR_W / 2;

    always_comb begin
        lma_bad = lma ? !host64 : (host64 || guest64);
        h32_bad = !host64 && (guest64 || (rip[ADDR_W-1:HALF] != '0));
        h64_bad = host64 && (!cr4_pae || !is_canon(64'(rip), CANON_MSB));
        smm_bad = (!in_smm && (smm_entry || dual_off)) || (smm_entry && dual_off);
    end
endmodule

// File: rtl/hsc_addr_rules.sv
module hsc_addr_rules
    import hsc_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CNT_W     = 32,
    parameter int MAX_PA    = 52,
    parameter int MIN_PA    = 32,
    parameter int CANON_MSB = 47
) (
    input  logic [PAW_W-1:0]                pa_width,
    input  logic [ADDR_W-1:0]               cr3,
    input  logic [ADDR_W-1:0]               msr_addr,
    input  logic [CNT_W-1:0]                msr_count,
    input  logic [N_CANON-1:0][ADDR_W-1:0]  lin_addrs,
    output logic                            cr3_bad,
    output logic                            msr_bad,
    output logic                            canon_bad,
    output logic                            paw_bad
);
    localparam int SUM_W = ADDR_W + CNT_W + 5;

    logic [PAW_W-1:0] eff_w;
    logic [SUM_W-1:0] last_byte;
    logic [N_CANON-1:0] canon_hit;

    for (genvar g = 0; g < N_CANON; g++) begin : g_canon
        assign canon_hit[g] = !is_canon(64'(lin_addrs[g]), CANON_MSB);
    end

    always_comb begin
        eff_w     = (int'(pa_width) > MAX_PA) ? PAW_W'(MAX_PA) : pa_width;
        last_byte = SUM_W'(msr_addr) + (SUM_W'(msr_count) << 4) - SUM_W'(1);
        paw_bad   = (int'(pa_width) < MIN_PA) || (int'(pa_width) > MAX_PA);
        cr3_bad   = (cr3 >> eff_w) != '0;
        msr_bad   = (msr_count != '0) && ((last_byte >> eff_w) != '0);
        canon_bad = |canon_hit;
    end
endmodule

// File: rtl/host_state_checker.sv
module host_state_checker
    import hsc_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 16,
    parameter int MAX_PA    = 52,
    parameter int MIN_PA    = 32,
    parameter int CANON_MSB = 47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [5:0]        pa_width,
    input  logic              lma,
    input  logic              host64,
    input  logic              guest64,
    input  logic              smm_entry,
    input  logic              dual_off,
    input  logic              in_smm,
    input  logic              cr4_pae,
    input  logic [ADDR_W-1:0] host_cr3,
    input  logic [ADDR_W-1:0] host_rip,
    input  logic [ADDR_W-1:0] sysenter_esp,
    input  logic [ADDR_W-1:0] sysenter_eip,
    input  logic [ADDR_W-1:0] fs_base,
    input  logic [ADDR_W-1:0] gs_base,
    input  logic [ADDR_W-1:0] gdtr_base,
    input  logic [ADDR_W-1:0] idtr_base,
    input  logic [ADDR_W-1:0] tr_base,
    input  logic [SEL_W-1:0]  sel_cs,
    input  logic [SEL_W-1:0]  sel_ss,
    input  logic [SEL_W-1:0]  sel_ds,
    input  logic [SEL_W-1:0]  sel_es,
    input  logic [SEL_W-1:0]  sel_fs,
    input  logic [SEL_W-1:0]  sel_gs,
    input  logic [SEL_W-1:0]  sel_tr,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic [CNT_W-1:0]  msr_count,
    output logic              done,
    output logic              pass,
    output logic [9:0]        err
);
    logic [N_SEL-1:0][SEL_W-1:0]    sels;
    logic [N_CANON-1:0][ADDR_W-1:0] lins;
    logic [ERR_W-1:0] err_c;
    hsc_result_t      res_q;

    assign sels = {sel_tr, sel_gs, sel_fs, sel_es, sel_ds, sel_ss, sel_cs};
    assign lins = {tr_base, idtr_base, gdtr_base, gs_base, fs_base,
                   sysenter_eip, sysenter_esp};

    hsc_sel_rules #(.SEL_W(SEL_W)) u_sel (
        .sels     (sels),
        .host64   (host64),
        .low_bad  (err_c[E_SEL_BITS]),
        .null_bad (err_c[E_SEL_NULL])
    );

    hsc_mode_rules #(.ADDR_W(ADDR_W), .CANON_MSB(CANON_MSB)) u_mode (
        .lma       (lma),
        .host64    (host64),
        .guest64   (guest64),
        .cr4_pae   (cr4_pae),
        .rip       (host_rip),
        .smm_entry (smm_entry),
        .dual_off  (dual_off),
        .in_smm    (in_smm),
        .lma_bad   (err_c[E_LMA]),
        .h32_bad   (err_c[E_HOST32]),
        .h64_bad   (err_c[E_HOST64]),
        .smm_bad   (err_c[E_SMM])
    );

    hsc_addr_rules #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_PA(MAX_PA),
        .MIN_PA(MIN_PA), .CANON_MSB(CANON_MSB)
    ) u_addr (
        .pa_width  (pa_width),
        .cr3       (host_cr3),
        .msr_addr  (msr_addr),
        .msr_count (msr_count),
        .lin_addrs (lins),
        .cr3_bad   (err_c[E_CR3]),
        .msr_bad   (err_c[E_MSR]),
        .canon_bad (err_c[E_CANON]),
        .paw_bad   (err_c[E_PAW])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                res_q.err  <= err_c;
                res_q.pass <= ~|err_c;
            end
        end
    end

    assign pass = res_q.pass;
    assign err  = res_q.err;

    // R11: result strobe follows the start strobe by one cycle
    a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(err) && $stable(pass));
    a_r2_cs_null: assert property (@(posedge clk) disable iff (rst)
        (start && sel_cs == '0) |=> (err[E_SEL_NULL] && !pass));
    a_r3_lma_host: assert property (@(posedge clk) disable iff (rst)
        (start && lma && !host64) |=> err[E_LMA]);
    a_r8_smm_both: assert property (@(posedge clk) disable iff (rst)
        (start && smm_entry && dual_off) |=> err[E_SMM]);
    a_r10_paw_low: assert property (@(posedge clk) disable iff (rst)
        (start && pa_width < 6'(MIN_PA)) |=> err[E_PAW]);
endmodule

// File: tb/host_state_checker_tb_top.sv
module host_state_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;
    localparam logic [9:0] EXP [NV] = '{
        10'h000, 10'h001, 10'h001, 10'h002, 10'h004, 10'h00C, 10'h002,
        10'h00C, 10'h010, 10'h010, 10'h020, 10'h000, 10'h000, 10'h040,
        10'h000, 10'h080, 10'h080, 10'h000, 10'h100, 10'h100, 10'h200,
        10'h200, 10'h020, 10'h000, 10'h040 };

    logic clk = 0, rst = 1, start = 0;
    logic [5:0] pa_width;
    logic lma, host64, guest64, smm_entry, dual_off, in_smm, cr4_pae;
    logic [63:0] host_cr3, host_rip, sysenter_esp, sysenter_eip;
    logic [63:0] fs_base, gs_base, gdtr_base, idtr_base, tr_base, msr_addr;
    logic [15:0] sel_cs, sel_ss, sel_ds, sel_es, sel_fs, sel_gs, sel_tr;
    logic [31:0] msr_count;
    logic done, pass;
    logic [9:0] err;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_state_checker dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_base();
        pa_width = 6'd40; lma = 1; host64 = 1; guest64 = 0;
        smm_entry = 0; dual_off = 0; in_smm = 0; cr4_pae = 1;
        host_cr3 = 64'h1000; host_rip = 64'hFFFF_8000_0000_1000;
        sysenter_esp = 0; sysenter_eip = 0; fs_base = 0; gs_base = 0;
        gdtr_base = 0; idtr_base = 0; tr_base = 0;
        sel_cs = 16'h08; sel_ss = 16'h10; sel_ds = 16'h18; sel_es = 16'h18;
        sel_fs = 16'h18; sel_gs = 16'h18; sel_tr = 16'h40;
        msr_addr = 64'h1000; msr_count = 2;
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R11";  1, 2: return "R1"; 3, 6: return "R2";
            4: return "R3";   5, 7: return "R3 R4"; 8, 9: return "R5";
            10, 11, 22, 23: return "R6"; 12, 13, 14, 24: return "R7";
            15, 16, 17: return "R8"; 18, 19: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input int i);
        set_base();
        case (i)
            1:  sel_ds = 16'h1B;
            2:  sel_tr = 16'h44;
            3:  sel_cs = 16'h0;
            4:  lma = 0;
            5:  host64 = 0;
            6:  begin lma = 0; host64 = 0; host_rip = 64'h1000; sel_ss = 0; end
            7:  begin lma = 0; host64 = 0; host_rip = 64'h1000; guest64 = 1; end
            8:  cr4_pae = 0;
            9:  host_rip = 64'h0000_8000_0000_0000;
            10: host_cr3 = 64'h1 << 40;
            11: host_cr3 = 64'h1 << 39;
            12: msr_addr = (64'h1 << 40) - 64'd32;
            13: msr_addr = (64'h1 << 40) - 64'd16;
            14: begin msr_count = 0; msr_addr = 64'h1 << 50; end
            15: smm_entry = 1;
            16: begin smm_entry = 1; dual_off = 1; in_smm = 1; end
            17: begin dual_off = 1; in_smm = 1; end
            18: fs_base = 64'h0000_8000_0000_0000;
            19: sysenter_eip = 64'hFFFF_0000_0000_0000;
            20: pa_width = 6'd31;
            21: pa_width = 6'd53;
            22: begin pa_width = 6'd52; host_cr3 = 64'h1 << 52; end
            23: begin pa_width = 6'd52; host_cr3 = 64'h1 << 51; end
            24: msr_addr = 64'hFFFF_FFFF_FFFF_FFF0;
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        set_base();
        repeat (3) @(negedge clk);
        check("R11 reset done", 32'(done), 0);
        check("R11 reset pass", 32'(pass), 0);
        check("R11 reset err", 32'(err), 0);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(i);
            start = 1;
            @(negedge clk);
            start = 0;
            check({tag_of(i), " done"}, 32'(done), 1);
            check({tag_of(i), " err"}, 32'(err), 32'(EXP[i]));
            check({tag_of(i), " pass"}, 32'(pass), 32'(EXP[i] == 0));
        end
        // R11: done is single-cycle and the result holds without start
        apply(3);
        @(negedge clk);
        check("R11 done drops", 32'(done), 0);
        check("R11 hold err", 32'(err), 32'(EXP[24]));
        @(negedge clk);
        check("R11 hold after input change", 32'(err), 32'(EXP[24]));
        // R11: back-to-back starts, each result lands one cycle later
        apply(15); start = 1;
        @(negedge clk);
        apply(0);
        check("R11 back-to-back first", 32'(err), 32'h080);
        @(negedge clk);
        start = 0;
        check("R11 back-to-back second", 32'(err), 0);
        check("R11 back-to-back pass", 32'(pass), 1);
        check("R11 back-to-back done", 32'(done), 1);
        @(negedge clk);
        finish_run();
    end
endmodule